// File: doc/BRIEF.md
# T1/E1 Transmit Error Injector

This block sits in the transmit path, after the line encoder has produced the positive and negative rails and before those rails leave for the line driver. On command it corrupts the outgoing stream in a controlled way. It can place a line-code violation, invert one framing bit, or invert one CRC bit. It can also ask the framer to move its frame alignment by one bit position. Software arms each error with a write strobe and a bit mask. Each armed request waits until the stream reaches a position where that error can be placed. It then fires exactly once and clears itself.

The rails pass through one register stage. A running polarity-swap state keeps the output a valid alternating-mark stream around every inserted error. The frame-bit and CRC-bit markers come from the framer, aligned with the rail bits. The slip pulses go back to the framer's read-pointer logic.

Top module: `txerr_inject`

## Requirements
- R1: A write with `wr_en` high and a 1 in a mask bit arms that request. The matching `pend` bit reads 1 on the cycle after the write. Mask encoding: bit0 line-code violation, bit1 frame-bit error, bit2 CRC-bit error, bit3 alignment change, bit4 slip direction. `pend` uses bit positions 0 to 3 for the same four requests.
- R2: A 0 in a mask bit leaves that request unchanged. A write of an all-zero mask alters neither `pend`, the rails, nor the slip outputs.
- R3: Several requests may be armed by a single write. Each one fires at its own position.
- R4: A write to a request that is still pending is merged into it and does not queue a second error. This also holds for a write in the very cycle in which the request fires.
- R5: T1 mode (`mode_e1`=0), and E1 without HDB3: the violation fires on the first bit, at least one cycle after the write, that meets all of these conditions: the input bit is a mark, the previous input bit was a mark, and the bit carries no frame or CRC marker. That mark goes out with the polarity of the previous mark. Exactly one bipolar violation results, and the mark/space pattern is not changed.
- R6: E1 with HDB3 (`mode_e1`=1, `hdb3_en`=1): the same position is used, but the violation gives two successive bipolar violations of the same polarity, with the mark/space pattern unchanged.
- R7: A frame-bit request inverts the mark/space value of the next bit flagged by `fbit_mark`. A mark becomes a space; a space becomes a mark of the opposite polarity to the last mark sent. No bipolar violation is added.
- R8: A CRC request inverts the next bit flagged by `crc_mark` in the same way, in either mode, and adds no bipolar violation.
- R9: In E1 mode an alignment request fires at the next frame-bit marker. It pulses `slip_ins` when the latched direction bit is 1 and `slip_del` when it is 0. The pulse comes one cycle after the marked input bit, aligned with that bit on the output.
- R10: In T1 mode an alignment request always pulses `slip_del`, whatever the direction bit. `slip_ins` stays low.
- R11: Each `pend` bit falls on the clock edge that applies its error.
- R12: While reset is asserted, the rails, the slip outputs and `pend` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| hdb3_en | input | 1 | E1 line code is HDB3 (double-violation form) |
| wr_en | input | 1 | Request write strobe |
| wr_mask | input | 5 | Request bits: violation, frame, CRC, alignment, direction |
| pos_in | input | 1 | Encoded positive rail from the line encoder |
| neg_in | input | 1 | Encoded negative rail from the line encoder |
| fbit_mark | input | 1 | Current bit is a frame/alignment bit |
| crc_mark | input | 1 | Current bit is a CRC bit |
| pos_out | output | 1 | Positive rail after injection |
| neg_out | output | 1 | Negative rail after injection |
| slip_del | output | 1 | One-cycle request to drop one bit position |
| slip_ins | output | 1 | One-cycle request to add one bit position |
| pend | output | 4 | Pending status of the four requests |

## Verification
The hardest case to reach from the ports is a write that lands on a request in the same cycle that request fires. Only that write can expose a merge that accidentally re-arms the request. The stimulus gets there by choosing a data pattern whose first eligible violation position is the bit right after the arming write, and then writing the violation bit a second time on that very bit. Every other case runs a fixed marker layout and a computed mark pattern. The bench works out the first eligible position, the violation count and the changed bits arithmetically, and then compares the whole output stream.

// File: rtl/txerr_pkg.sv
`timescale 1ns/1ps
package txerr_pkg;
  localparam int NREQ   = 4;
  localparam int MASK_W = NREQ + 1;
  localparam int IX_LCV = 0;
  localparam int IX_FRM = 1;
  localparam int IX_CRC = 2;
  localparam int IX_ALN = 3;
  localparam int IX_DIR = 4;
  typedef logic [NREQ-1:0] req_vec_t;
endpackage

// File: rtl/txerr_req.sv
`timescale 1ns/1ps
module txerr_req
  import txerr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  req_vec_t wr_bits,
  input  req_vec_t fire,
  output req_vec_t pend
);
  req_vec_t pend_q, pend_n;

  for (genvar k = 0; k < NREQ; k++) begin : g_req
    // pending: cleared by its own firing (a same-cycle write merges in);
    // idle: armed by a write of 1
    always_comb begin
      if (pend_q[k]) pend_n[k] = ~fire[k];
      else           pend_n[k] = wr_en & wr_bits[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[k] <= 1'b0;
      else        pend_q[k] <= pend_n[k];
    end

    a_r1_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bits[k] && !pend_q[k]) |=> pend_q[k]);
    a_r2_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[k] && !(wr_en && wr_bits[k])) |=> !pend_q[k]);
    a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
      fire[k] |=> !pend_q[k]);
    a_r4_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[k] && !fire[k]) |=> pend_q[k]);
  end

  assign pend = pend_q;
endmodule

// File: rtl/txerr_slip.sv
`timescale 1ns/1ps
module txerr_slip (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_e1,
  input  logic wr_en,
  input  logic arm_bit,
  input  logic dir_bit,
  input  logic pend_aln,
  input  logic fbit_mark,
  output logic fire_aln,
  output logic slip_del,
  output logic slip_ins
);
  logic dir_q, dir_n;
  logic del_q, del_n;
  logic ins_q, ins_n;

  always_comb begin
    fire_aln = pend_aln & fbit_mark;
    // direction is captured only when the request is newly armed
    dir_n = (wr_en & arm_bit & ~pend_aln) ? dir_bit : dir_q;
    ins_n = fire_aln & mode_e1 & dir_q;
    del_n = fire_aln & ~(mode_e1 & dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      del_q <= 1'b0;
      ins_q <= 1'b0;
    end else begin
      dir_q <= dir_n;
      del_q <= del_n;
      ins_q <= ins_n;
    end
  end

  assign slip_del = del_q;
  assign slip_ins = ins_q;

  a_r9_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(slip_del && slip_ins));
  a_r10_t1_delete_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_e1 |=> !slip_ins);
  a_r9_pulse_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_aln |=> (slip_del || slip_ins));
  a_r9_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_aln |=> !(slip_del || slip_ins));
endmodule

// File: rtl/txerr_rail.sv
`timescale 1ns/1ps
module txerr_rail (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_viol,
  input  logic pos_in,
  input  logic neg_in,
  input  logic fbit_mark,
  input  logic crc_mark,
  input  logic pend_lcv,
  input  logic pend_frm,
  input  logic pend_crc,
  output logic fire_lcv,
  output logic fire_frm,
  output logic fire_crc,
  output logic pos_out,
  output logic neg_out
);
  logic swap_q, swap_n;
  logic last_q, last_n;   // polarity of last mark sent, 1 = positive
  logic prev_q, prev_n;   // previous input bit was a mark
  logic p_q, p_n, n_q, n_n;
  logic in_mark, sw_p, sw_n, inv;

  always_comb begin
    in_mark  = pos_in | neg_in;
    sw_p     = swap_q ? neg_in : pos_in;
    sw_n     = swap_q ? pos_in : neg_in;
    fire_frm = pend_frm & fbit_mark;
    fire_crc = pend_crc & crc_mark;
    inv      = fire_frm | fire_crc;
    fire_lcv = pend_lcv & in_mark & prev_q & ~fbit_mark & ~crc_mark;
    p_n      = sw_p;
    n_n      = sw_n;
    swap_n   = swap_q;
    if (inv) begin
      if (in_mark) begin
        p_n = 1'b0;
        n_n = 1'b0;
      end else begin
        p_n = ~last_q;
        n_n = last_q;
      end
      swap_n = ~swap_q;
    end else if (fire_lcv) begin
      p_n = sw_n;
      n_n = sw_p;
      if (!dbl_viol) swap_n = ~swap_q;
    end
    last_n = (p_n | n_n) ? p_n : last_q;
    prev_n = in_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= 1'b0;
      last_q <= 1'b0;
      prev_q <= 1'b0;
      p_q    <= 1'b0;
      n_q    <= 1'b0;
    end else begin
      swap_q <= swap_n;
      last_q <= last_n;
      prev_q <= prev_n;
      p_q    <= p_n;
      n_q    <= n_n;
    end
  end

  assign pos_out = p_q;
  assign neg_out = n_q;

  a_r7_frame_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    fire_frm |=> ((pos_out || neg_out) != $past(pos_in || neg_in)));
  a_r8_crc_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    fire_crc |=> ((pos_out || neg_out) != $past(pos_in || neg_in)));
  a_r5_mark_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fire_lcv |=> (pos_out ^ neg_out));
  a_r5_rails_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_in && neg_in) |=> !(pos_out && neg_out));
endmodule

// File: rtl/txerr_inject.sv
`timescale 1ns/1ps
module txerr_inject
  import txerr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_e1,
  input  logic              hdb3_en,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              pos_in,
  input  logic              neg_in,
  input  logic              fbit_mark,
  input  logic              crc_mark,
  output logic              pos_out,
  output logic              neg_out,
  output logic              slip_del,
  output logic              slip_ins,
  output logic [NREQ-1:0]   pend
);
  logic     rs_q1, rs_q2;
  req_vec_t pend_v, fire_v;
  logic     f_lcv, f_frm, f_crc, f_aln;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  always_comb begin
    fire_v         = '0;
    fire_v[IX_LCV] = f_lcv;
    fire_v[IX_FRM] = f_frm;
    fire_v[IX_CRC] = f_crc;
    fire_v[IX_ALN] = f_aln;
  end

  txerr_req u_req (
    .clk     (clk),
    .rst_n   (rs_q2),
    .wr_en   (wr_en),
    .wr_bits (wr_mask[NREQ-1:0]),
    .fire    (fire_v),
    .pend    (pend_v)
  );

  txerr_rail u_rail (
    .clk       (clk),
    .rst_n     (rs_q2),
    .dbl_viol  (mode_e1 & hdb3_en),
    .pos_in    (pos_in),
    .neg_in    (neg_in),
    .fbit_mark (fbit_mark),
    .crc_mark  (crc_mark),
    .pend_lcv  (pend_v[IX_LCV]),
    .pend_frm  (pend_v[IX_FRM]),
    .pend_crc  (pend_v[IX_CRC]),
    .fire_lcv  (f_lcv),
    .fire_frm  (f_frm),
    .fire_crc  (f_crc),
    .pos_out   (pos_out),
    .neg_out   (neg_out)
  );

  txerr_slip u_slip (
    .clk       (clk),
    .rst_n     (rs_q2),
    .mode_e1   (mode_e1),
    .wr_en     (wr_en),
    .arm_bit   (wr_mask[IX_ALN]),
    .dir_bit   (wr_mask[IX_DIR]),
    .pend_aln  (pend_v[IX_ALN]),
    .fbit_mark (fbit_mark),
    .fire_aln  (f_aln),
    .slip_del  (slip_del),
    .slip_ins  (slip_ins)
  );

  assign pend = pend_v;

  a_r12_reset_quiet: assert property (@(posedge clk)
    !rs_q2 |-> (!pos_out && !neg_out && !slip_del && !slip_ins && pend == '0));
  a_r3_fire_needs_pend: assert property (@(posedge clk) disable iff (!rs_q2)
    (fire_v & ~pend_v) == '0);
endmodule

// File: tb/sim_txerr_inject.sv
`timescale 1ns/1ps
module sim_txerr_inject;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_e1, hdb3_en, wr_en;
  logic [4:0] wr_mask;
  logic       pos_in, neg_in, fbit_mark, crc_mark;
  logic       pos_out, neg_out, slip_del, slip_ins;
  logic [3:0] pend;

  localparam int N = 40;

  int   total = 0;
  int   bad   = 0;
  logic dif  [0:63];
  logic bpv  [0:63];
  logic sdel [0:63];
  logic sins [0:63];
  logic outp [0:63];
  logic [3:0] pnd [0:63];
  int   ndif, nbpv, ndel, nins;

  always #2 clk = ~clk;

  txerr_inject u0 (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .hdb3_en(hdb3_en),
    .wr_en(wr_en), .wr_mask(wr_mask), .pos_in(pos_in), .neg_in(neg_in),
    .fbit_mark(fbit_mark), .crc_mark(crc_mark), .pos_out(pos_out),
    .neg_out(neg_out), .slip_del(slip_del), .slip_ins(slip_ins), .pend(pend)
  );

  function automatic logic dat(int i, int s);
    return ((i * 5 + s) % 7) < 4;
  endfunction
  function automatic logic fbm(int i);
    return (i % 16) == 4;
  endfunction
  function automatic logic cmk(int i);
    return (i % 16) == 12;
  endfunction
  function automatic int first_lcv(int s);
    for (int i = 1; i < N; i++)
      if (dat(i, s) && dat(i - 1, s) && !fbm(i) && !cmk(i)) return i;
    return -1;
  endfunction
  function automatic int next_mark(int e, int s);
    for (int j = e + 1; j < N; j++) if (dat(j, s)) return j;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic h);
    rst_n = 1'b0; mode_e1 = m; hdb3_en = h; wr_en = 1'b0; wr_mask = '0;
    pos_in = 1'b0; neg_in = 1'b0; fbit_mark = 1'b0; crc_mark = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive N bits; writes at index 0 (mask m0) and index 1 (mask m1)
  task automatic run(input logic m, input logic h, input int s,
                     input logic [4:0] m0, input logic [4:0] m1);
    logic apol, seen, lastp, uo;
    do_reset(m, h);
    apol = 1'b0; seen = 1'b0; lastp = 1'b0;
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        uo = pos_out | neg_out;
        dif[i-1]  = (uo != dat(i - 1, s));
        bpv[i-1]  = uo && seen && (pos_out == lastp);
        if (uo) begin lastp = pos_out; seen = 1'b1; end
        sdel[i-1] = slip_del;
        sins[i-1] = slip_ins;
        outp[i-1] = pos_out;
        pnd[i-1]  = pend;
      end
      if (i < N) begin
        if (dat(i, s)) begin
          pos_in = ~apol; neg_in = apol; apol = ~apol;
        end else begin
          pos_in = 1'b0; neg_in = 1'b0;
        end
        fbit_mark = fbm(i);
        crc_mark  = cmk(i);
        wr_en     = (i < 2);
        wr_mask   = (i == 0) ? m0 : ((i == 1) ? m1 : 5'd0);
      end else begin
        pos_in = 1'b0; neg_in = 1'b0; fbit_mark = 1'b0; crc_mark = 1'b0;
        wr_en = 1'b0; wr_mask = '0;
      end
    end
    ndif = 0; nbpv = 0; ndel = 0; nins = 0;
    for (int i = 0; i < N; i++) begin
      ndif += int'(dif[i]); nbpv += int'(bpv[i]);
      ndel += int'(sdel[i]); nins += int'(sins[i]);
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, j;
    // R12 reset state
    do_reset(1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!pos_out && !neg_out && !slip_del && !slip_ins && pend == 4'd0,
        "R12 reset", int'({pos_out, neg_out, slip_del, slip_ins, pend}), 0);

    // R5 T1 single violation
    run(1'b0, 1'b0, 3, 5'b00001, 5'b00000);
    e = first_lcv(3);
    chk(pnd[0][0] == 1'b1, "R1 armed", int'(pnd[0][0]), 1);
    chk(bpv[e] == 1'b1 && nbpv == 1, "R5 t1 one bpv", nbpv, 1);
    chk(ndif == 0, "R5 marks kept", ndif, 0);
    chk(pnd[e][0] == 1'b0, "R11 drop at fire", int'(pnd[e][0]), 0);

    // R6 E1 HDB3 double violation
    run(1'b1, 1'b1, 3, 5'b00001, 5'b00000);
    j = next_mark(e, 3);
    chk(nbpv == 2 && bpv[e] && bpv[j], "R6 two bpv", nbpv, 2);
    chk(outp[e] == outp[j], "R6 same polarity", int'(outp[j]), int'(outp[e]));
    chk(ndif == 0, "R6 marks kept", ndif, 0);

    // R5 E1 without HDB3 behaves as single violation
    run(1'b1, 1'b0, 3, 5'b00001, 5'b00000);
    chk(nbpv == 1 && bpv[e], "R5 e1 ami one bpv", nbpv, 1);

    // R7 frame bit, space becomes mark
    run(1'b0, 1'b0, 0, 5'b00010, 5'b00000);
    chk(ndif == 1 && dif[4], "R7 frame inverted", ndif, 1);
    chk(nbpv == 0, "R7 no bpv", nbpv, 0);
    chk(pnd[1][1] == 1'b1, "R2 zero write keeps pend", int'(pnd[1][1]), 1);

    // R8 CRC bit in E1
    run(1'b1, 1'b0, 0, 5'b00100, 5'b00000);
    chk(ndif == 1 && dif[12], "R8 crc inverted", ndif, 1);
    chk(nbpv == 0, "R8 no bpv", nbpv, 0);

    // R3 several at once (marks removed at 4 and 12)
    run(1'b0, 1'b0, 3, 5'b00111, 5'b00000);
    chk(ndif == 2 && dif[4] && dif[12], "R3 frame and crc", ndif, 2);
    chk(nbpv == 1 && bpv[e], "R3 violation too", nbpv, 1);
    chk(pnd[20] == 4'd0, "R3 all cleared", int'(pnd[20]), 0);

    // R4 merge: rewrite on the firing cycle, and while waiting
    run(1'b0, 1'b0, 3, 5'b00001, 5'b00001);
    chk(e == 1, "R4 setup fire at 1", e, 1);
    chk(nbpv == 1, "R4 merged on fire", nbpv, 1);
    run(1'b0, 1'b0, 3, 5'b00010, 5'b00010);
    chk(ndif == 1, "R4 merged pending", ndif, 1);

    // R2 zero writes
    run(1'b0, 1'b0, 3, 5'b00000, 5'b00000);
    chk(pnd[1] == 4'd0, "R2 no arm", int'(pnd[1]), 0);
    chk(ndif == 0 && nbpv == 0 && ndel == 0 && nins == 0,
        "R2 stream untouched", ndif + nbpv + ndel + nins, 0);

    // R10 T1 delete only
    run(1'b0, 1'b0, 3, 5'b11000, 5'b00000);
    chk(sdel[4] && ndel == 1, "R10 t1 delete", ndel, 1);
    chk(nins == 0, "R10 no insert", nins, 0);
    chk(pnd[4][3] == 1'b0 && pnd[3][3] == 1'b1, "R11 align drop",
        int'(pnd[4][3]), 0);

    // R9 E1 directions
    run(1'b1, 1'b0, 3, 5'b11000, 5'b00000);
    chk(sins[4] && nins == 1 && ndel == 0, "R9 e1 insert", nins, 1);
    run(1'b1, 1'b0, 3, 5'b01000, 5'b00000);
    chk(sdel[4] && ndel == 1 && nins == 0, "R9 e1 delete", ndel, 1);
    chk(ndif == 0 && nbpv == 0, "R9 rails untouched", ndif + nbpv, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule